// File: doc/BRIEF.md
# Floating-Point Compare with Status Flags

This block compares two IEEE-754 binary64 operands and reports their relation as a one-hot four-bit condition code. The caller selects ordered or unordered compare semantics, names the destination condition-register field by a three-bit index and supplies the current invalid-operation enable bit. The block returns the code, the field index and a set-mask of exception flags. The owner of the status register ORs this mask into its sticky bits and also copies the code into the status compare field at bits [15:12]. Neither the condition register nor the status register is held here.

A request is a single-cycle strobe. The compare and the flag logic are combinational. One output register stage aligns the result with a single-cycle result strobe. Outside that strobe the result outputs are driven to zero, so the consumer can gate its register writes with the strobe alone.

Top module: `fpcmp_unit`

## Requirements
- R1: If either operand is a NaN (exponent all ones, fraction non-zero), the code is 4'b0001 (unordered), whatever the other operand is.
- R2: For non-NaN operands the order is sign-magnitude on the raw bit patterns. Every negative value is below every positive value, and among negatives a larger magnitude is smaller. The code is 4'b1000 when a is below b and 4'b0100 when a is above b. Infinities are included.
- R3: Non-NaN operands with equal value give code 4'b0010. Positive zero and negative zero count as equal.
- R4: Whenever a result is valid, exactly one bit of the code is set.
- R5: A signalling NaN (NaN with fraction bit 51 clear) in either operand sets bit 24 (invalid: signalling NaN) and bit 31 (exception summary) of the flag mask, in both compare modes.
- R6: In ordered mode, a signalling NaN with the enable input low also sets bit 19 (invalid: compare). With the enable input high, bit 19 stays clear.
- R7: In ordered mode, a quiet NaN in either operand with no signalling NaN present sets bit 19 and bit 31, and leaves bit 24 clear.
- R8: In unordered mode, quiet NaNs raise no flag. Non-NaN operands raise no flag in either mode. In both cases the mask is all zero.
- R9: A request strobed in one cycle produces its code, its field index and its flag mask with the result strobe high in the following cycle. In cycles without the result strobe, the code, the index and the mask are zero.
- R10: While reset is active and after it, until the first request, the result strobe, the code, the index and the mask are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_vld_i | input | 1 | Single-cycle request strobe |
| opa_i | input | 64 | Operand a, binary64 bit pattern |
| opb_i | input | 64 | Operand b, binary64 bit pattern |
| ordered_i | input | 1 | 1 = ordered compare, 0 = unordered compare |
| ve_i | input | 1 | Current invalid-operation enable bit |
| fld_idx_i | input | 3 | Destination condition-register field |
| res_vld_o | output | 1 | Result strobe, one cycle after the request |
| cc_o | output | 4 | One-hot code: 8 less, 4 greater, 2 equal, 1 unordered |
| fld_idx_o | output | 3 | Field index carried with the result |
| stat_set_o | output | 32 | Flag bits to OR into the status register |

## Verification
The hardest case to reach is the point where the compare mode, the enable bit and the NaN kind interact. That is a signalling NaN under ordered compare, with the enable both high and low, and also with a quiet NaN in the other operand, so that the priority of the signalling case shows. Directed requests build these bit patterns explicitly: quiet bit clear with a non-zero fraction, and quiet bit set. Signed zeros, infinities and same-sign negatives are aimed at the order logic. A long stream of back-to-back requests then mixes special encodings with random and equal operands, so that the one-cycle pipeline never idles between items.

// File: rtl/fpcmp_pkg.sv
// Package: shared codes, status bit positions and the operand class record
// for the floating-point compare block. Assumes a 32-bit status register
// whose bit 31 is the exception summary.
package fpcmp_pkg;

    // One-hot condition codes
    localparam logic [3:0] CC_LT = 4'b1000;
    localparam logic [3:0] CC_GT = 4'b0100;
    localparam logic [3:0] CC_EQ = 4'b0010;
    localparam logic [3:0] CC_UN = 4'b0001;

    // Status register bit positions decoded by the status owner
    localparam int unsigned ST_SUMMARY_BIT = 31;
    localparam int unsigned ST_SNAN_BIT    = 24;
    localparam int unsigned ST_CMP_BIT     = 19;

    // Per-operand classification
    typedef struct packed {
        logic sign;
        logic is_zero;
        logic is_nan;
        logic is_snan;
    } fpcmp_class_t;

endpackage

// File: rtl/fpcmp_classify.sv
// Module: fpcmp_classify
// Splits one binary floating-point pattern into sign, magnitude and class
// flags. Assumes the usual layout: sign on top, then exponent, then fraction,
// with the quiet bit as the fraction MSB.
module fpcmp_classify
    import fpcmp_pkg::*;
#(
    parameter int unsigned EXP_W  = 11,
    parameter int unsigned FRAC_W = 52,
    localparam int unsigned OP_W  = 1 + EXP_W + FRAC_W
) (
    input  logic [OP_W-1:0]   op_i,
    output fpcmp_class_t      cls_o,
    output logic [OP_W-2:0]   mag_o
);

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    assign exp_f  = op_i[OP_W-2 -: EXP_W];
    assign frac_f = op_i[FRAC_W-1:0];

    // Decode the class flags from the exponent and fraction fields
    always_comb begin
        cls_o.sign    = op_i[OP_W-1];
        cls_o.is_zero = (exp_f == '0) && (frac_f == '0);
        cls_o.is_nan  = (exp_f == '1) && (frac_f != '0);
        cls_o.is_snan = cls_o.is_nan && !frac_f[FRAC_W-1];
        mag_o         = op_i[OP_W-2:0];
    end

endmodule

// File: rtl/fpcmp_order.sv
// Module: fpcmp_order
// Turns two classified operands into the one-hot relation code. Assumes the
// magnitudes are the raw exponent|fraction fields, so an unsigned compare of
// them orders non-NaN values of the same sign.
module fpcmp_order
    import fpcmp_pkg::*;
#(
    parameter int unsigned MAG_W = 63
) (
    input  fpcmp_class_t     cls_a_i,
    input  fpcmp_class_t     cls_b_i,
    input  logic [MAG_W-1:0] mag_a_i,
    input  logic [MAG_W-1:0] mag_b_i,
    output logic [3:0]       code_o
);

    logic mag_lt;
    logic mag_eq;

    assign mag_lt = mag_a_i < mag_b_i;
    assign mag_eq = mag_a_i == mag_b_i;

    // Priority: NaN, signed zeros, sign split, then same-sign magnitude
    always_comb begin
        if (cls_a_i.is_nan || cls_b_i.is_nan) begin
            code_o = CC_UN;
        end else if (cls_a_i.is_zero && cls_b_i.is_zero) begin
            code_o = CC_EQ;
        end else if (cls_a_i.sign != cls_b_i.sign) begin
            code_o = cls_a_i.sign ? CC_LT : CC_GT;
        end else if (mag_eq) begin
            code_o = CC_EQ;
        end else if (!cls_a_i.sign) begin
            code_o = mag_lt ? CC_LT : CC_GT;
        end else begin
            code_o = mag_lt ? CC_GT : CC_LT;
        end
    end

endmodule

// File: rtl/fpcmp_excgen.sv
// Module: fpcmp_excgen
// Builds the status set-mask for a compare from the NaN kinds, the compare
// mode and the invalid-operation enable. Assumes STAT_W covers the highest
// flag position in the package.
module fpcmp_excgen
    import fpcmp_pkg::*;
#(
    parameter int unsigned STAT_W = 32
) (
    input  fpcmp_class_t      cls_a_i,
    input  fpcmp_class_t      cls_b_i,
    input  logic              ordered_i,
    input  logic              ve_i,
    output logic [STAT_W-1:0] set_o
);

    logic any_snan;
    logic any_qnan;

    assign any_snan = cls_a_i.is_snan || cls_b_i.is_snan;
    assign any_qnan = (cls_a_i.is_nan && !cls_a_i.is_snan) ||
                      (cls_b_i.is_nan && !cls_b_i.is_snan);

    // Raise the invalid flags; the signalling case takes precedence
    always_comb begin
        set_o = '0;
        if (any_snan) begin
            set_o[ST_SNAN_BIT]    = 1'b1;
            set_o[ST_SUMMARY_BIT] = 1'b1;
            if (ordered_i && !ve_i) begin
                set_o[ST_CMP_BIT] = 1'b1;
            end
        end else if (ordered_i && any_qnan) begin
            set_o[ST_CMP_BIT]     = 1'b1;
            set_o[ST_SUMMARY_BIT] = 1'b1;
        end
    end

endmodule

// File: rtl/fpcmp_unit.sv
// Module: fpcmp_unit
// Floating-point compare with status flags. The two operands are classified
// by a generated pair of classifiers. The relation code and the flag mask
// are formed combinationally, and one register stage presents them with a
// single-cycle result strobe. Assumes requests are single-cycle strobes.
// Outputs are zero whenever the strobe is low.
module fpcmp_unit
    import fpcmp_pkg::*;
#(
    parameter int unsigned EXP_W  = 11,
    parameter int unsigned FRAC_W = 52,
    parameter int unsigned FLD_W  = 3,
    parameter int unsigned STAT_W = 32,
    localparam int unsigned OP_W  = 1 + EXP_W + FRAC_W,
    localparam int unsigned MAG_W = OP_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld_i,
    input  logic [OP_W-1:0]   opa_i,
    input  logic [OP_W-1:0]   opb_i,
    input  logic              ordered_i,
    input  logic              ve_i,
    input  logic [FLD_W-1:0]  fld_idx_i,
    output logic              res_vld_o,
    output logic [3:0]        cc_o,
    output logic [FLD_W-1:0]  fld_idx_o,
    output logic [STAT_W-1:0] stat_set_o
);

    fpcmp_class_t     cls   [2];
    logic [MAG_W-1:0] mag   [2];
    logic [OP_W-1:0]  opnd  [2];
    logic [3:0]       code_c;
    logic [STAT_W-1:0] set_c;

    assign opnd[0] = opa_i;
    assign opnd[1] = opb_i;

    // One classifier per operand
    for (genvar gi = 0; gi < 2; gi++) begin : g_cls
        fpcmp_classify #(
            .EXP_W  (EXP_W),
            .FRAC_W (FRAC_W)
        ) cls_i (
            .op_i  (opnd[gi]),
            .cls_o (cls[gi]),
            .mag_o (mag[gi])
        );
    end

    fpcmp_order #(
        .MAG_W (MAG_W)
    ) order_i (
        .cls_a_i (cls[0]),
        .cls_b_i (cls[1]),
        .mag_a_i (mag[0]),
        .mag_b_i (mag[1]),
        .code_o  (code_c)
    );

    fpcmp_excgen #(
        .STAT_W (STAT_W)
    ) excgen_i (
        .cls_a_i   (cls[0]),
        .cls_b_i   (cls[1]),
        .ordered_i (ordered_i),
        .ve_i      (ve_i),
        .set_o     (set_c)
    );

    // Output stage: capture on a request, otherwise return to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld_o  <= 1'b0;
            cc_o       <= '0;
            fld_idx_o  <= '0;
            stat_set_o <= '0;
        end else if (req_vld_i) begin
            res_vld_o  <= 1'b1;
            cc_o       <= code_c;
            fld_idx_o  <= fld_idx_i;
            stat_set_o <= set_c;
        end else begin
            res_vld_o  <= 1'b0;
            cc_o       <= '0;
            fld_idx_o  <= '0;
            stat_set_o <= '0;
        end
    end

    // R9: a request yields a result strobe one cycle later
    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld_i |=> res_vld_o);

    // R9: the field index travels with its request
    p_idx_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld_i |=> (fld_idx_o == $past(fld_idx_i)));

    // R9: idle cycles present nothing
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !res_vld_o |-> (cc_o == '0 && stat_set_o == '0 && fld_idx_o == '0));

    // R4: a valid code has exactly one bit set
    p_code_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld_o |-> ($countones(cc_o) == 1));

    // R1: any invalid flag implies a NaN was seen, so the code is unordered
    p_flag_unord_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld_o && stat_set_o != '0) |-> (cc_o == CC_UN));

    // R5: any raised flag is accompanied by the summary bit
    p_summary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_set_o != '0) |-> stat_set_o[ST_SUMMARY_BIT]);

    // R8: unordered mode never raises the compare flag without a signalling NaN
    p_unord_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld_i && !ordered_i) |=> !stat_set_o[ST_CMP_BIT]);

endmodule

// File: tb/fpcmp_unit_tb_top.sv
`timescale 1ns/1ps
// Bench for fpcmp_unit: a driver task computes the expected result for each
// request and queues it, and a monitor pops and compares on every result strobe.
module fpcmp_unit_tb_top;

    typedef struct {
        logic [3:0]  cc;
        logic [2:0]  idx;
        logic [31:0] flags;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic        ordered = 1'b0;
    logic        ve = 1'b0;
    logic [2:0]  fidx = '0;
    logic        res_vld;
    logic [3:0]  cc;
    logic [2:0]  fidx_o;
    logic [31:0] flags;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;
    exp_t sb_q[$];

    localparam logic [63:0] QNAN  = 64'h7FF8_0000_0000_0001;
    localparam logic [63:0] SNAN  = 64'h7FF0_0000_0000_0003;
    localparam logic [63:0] PINF  = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] NINF  = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] MAXF  = 64'h7FEF_FFFF_FFFF_FFFF;
    localparam logic [63:0] PZERO = 64'h0;
    localparam logic [63:0] NZERO = 64'h8000_0000_0000_0000;

    always #2 clk = ~clk;

    fpcmp_unit dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_vld_i  (req_vld),
        .opa_i      (opa),
        .opb_i      (opb),
        .ordered_i  (ordered),
        .ve_i       (ve),
        .fld_idx_i  (fidx),
        .res_vld_o  (res_vld),
        .cc_o       (cc),
        .fld_idx_o  (fidx_o),
        .stat_set_o (flags)
    );

    function automatic bit m_nan(logic [63:0] x);
        return (x[62:52] == 11'h7FF) && (x[51:0] != 52'h0);
    endfunction

    function automatic bit m_snan(logic [63:0] x);
        return m_nan(x) && !x[51];
    endfunction

    function automatic void check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endfunction

    // Driver: present one request and queue its expected result
    task automatic drive(string tag, logic [63:0] a, logic [63:0] b, bit ord, bit en, logic [2:0] ix);
        exp_t e;
        real  ra, rb;
        bit   sn, qn;
        ra = $bitstoreal(a);
        rb = $bitstoreal(b);
        if (m_nan(a) || m_nan(b)) e.cc = 4'b0001;
        else if (ra < rb)         e.cc = 4'b1000;
        else if (ra > rb)         e.cc = 4'b0100;
        else                      e.cc = 4'b0010;
        sn = m_snan(a) || m_snan(b);
        qn = (m_nan(a) && !m_snan(a)) || (m_nan(b) && !m_snan(b));
        e.flags = '0;
        if (sn) begin
            e.flags[24] = 1'b1;
            e.flags[31] = 1'b1;
            if (ord && !en) e.flags[19] = 1'b1;
        end else if (ord && qn) begin
            e.flags[19] = 1'b1;
            e.flags[31] = 1'b1;
        end
        e.idx = ix;
        e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        req_vld = 1'b1;
        opa = a; opb = b; ordered = ord; ve = en; fidx = ix;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_vld = 1'b0;
        end
    endtask

    // Monitor: compare each produced result with the oldest queued item
    always @(negedge clk) begin
        if (rst_n && res_vld) begin
            if (sb_q.size() == 0) begin
                check("R9", "unexpected result strobe", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, "code/idx/flags",
                      {25'd0, cc, fidx_o, flags}, {25'd0, e.cc, e.idx, e.flags});
            end
        end
    end

    function automatic logic [63:0] pick(int k, logic [63:0] other);
        case (k)
            0: return {$urandom, $urandom};
            1: return QNAN | {1'b0, 11'h0, 1'b0, 19'h0, $urandom} | {$urandom_range(1), 63'h0};
            2: return SNAN | {$urandom_range(1), 63'h0};
            3: return {$urandom_range(1), 63'h0};
            4: return other;
            default: return $realtobits($itor($urandom_range(20)) - 10.0);
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", "res_vld in reset", {63'd0, res_vld}, 64'd0);
        check("R10", "outputs in reset", {25'd0, cc, fidx_o, flags}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", "outputs after reset", {24'd0, res_vld, cc, fidx_o, flags}, 64'd0);

        // R2: ordering of finite and infinite values
        drive("R2", $realtobits(1.0), $realtobits(2.0), 1'b0, 1'b0, 3'd0);
        drive("R2", $realtobits(2.0), $realtobits(1.0), 1'b1, 1'b0, 3'd1);
        drive("R2", $realtobits(-1.0), $realtobits(1.0), 1'b0, 1'b0, 3'd2);
        drive("R2", $realtobits(-3.0), $realtobits(-2.0), 1'b0, 1'b1, 3'd3);
        drive("R2", PINF, MAXF, 1'b1, 1'b1, 3'd4);
        drive("R2", NINF, $realtobits(-1.0), 1'b0, 1'b0, 3'd5);
        // R3: equality including signed zeros
        drive("R3", PZERO, NZERO, 1'b1, 1'b0, 3'd6);
        drive("R3", $realtobits(5.5), $realtobits(5.5), 1'b0, 1'b0, 3'd7);
        // R1 / R7: quiet NaN in ordered mode
        drive("R7", QNAN, $realtobits(1.0), 1'b1, 1'b0, 3'd1);
        drive("R1", PINF, QNAN, 1'b1, 1'b1, 3'd2);
        // R8: quiet NaN in unordered mode raises nothing
        drive("R8", QNAN, QNAN, 1'b0, 1'b0, 3'd3);
        // R5 / R6: signalling NaN in each mode and enable setting
        drive("R5", SNAN, $realtobits(3.0), 1'b0, 1'b0, 3'd4);
        drive("R6", $realtobits(3.0), SNAN, 1'b1, 1'b0, 3'd5);
        drive("R6", SNAN, PZERO, 1'b1, 1'b1, 3'd6);
        drive("R6", SNAN, QNAN, 1'b1, 1'b1, 3'd7);
        idle(3);
        // R9: idle cycles present zeros
        check("R9", "idle outputs", {24'd0, res_vld, cc, fidx_o, flags}, 64'd0);

        // R4: mixed back-to-back stream
        for (int i = 0; i < 300; i++) begin
            logic [63:0] a, b;
            a = pick($urandom_range(5), $realtobits(0.5));
            b = pick($urandom_range(5), a);
            drive("R4", a, b, 1'($urandom_range(1)), 1'($urandom_range(1)), 3'($urandom_range(7)));
        end
        idle(3);
        check("R9", "scoreboard drained", 64'(sb_q.size()), 64'd0);
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R9 watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule